// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block gathers a bank of level-sensitive interrupt lines into a single interrupt request for a processor. It holds a pending-status word with one bit per line and a mask word, one bit per line, that software writes. Status bits change only when a line changes level. A line going high sets its bit and a line going low clears its bit. The request output is high whenever a pending bit is also enabled in the mask.

One rule sets this block apart. Whenever a line changes level, the new status word is compared with the mask. If no enabled bit is pending, the whole status word is wiped, including bits for lines that are masked and may still be high. A mask write does not trigger this rule by itself. A small register port lets software read the status and the mask and write the mask. The status word is read-only. Vectoring, priority selection and exception entry belong to the processor and are not part of this block.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the status word, the mask word and `irq_req` are all zero.
- R2: On a clock edge where line n was low at the previous edge and is now high, status bit n becomes 1, provided the updated status has at least one bit enabled by the mask. This holds for every index, including the highest line.
- R3: On a clock edge where line n was high at the previous edge and is now low, status bit n becomes 0.
- R4: After every clock edge, `irq_req` equals the OR-reduction of (status AND mask) as held in the registers after that edge.
- R5: On an edge where any line changed level, if the updated status AND the mask held before that edge is zero, then the entire status word becomes zero, including bits of masked lines that are still high.
- R6: A rising line whose mask bit is clear, with no enabled bit pending, leaves status zero and `irq_req` low.
- R7: A write with `reg_addr` = 1 loads `reg_wdata` into the mask at the next clock edge. Before that edge, a read still returns the old mask.
- R8: A mask write alone never changes the status word. Only line level changes do, so status may keep bits that the new mask no longer enables.
- R9: A write with `reg_addr` = 0 (the status address) has no effect on the status word.
- R10: A line held at a steady level causes no status update, so a bit wiped by R5 stays zero until that line rises again.
- R11: Several lines changing on the same edge are all applied together before the R5 rule is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt inputs, one per line |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = status (read-only), 1 = mask |
| reg_wdata | input | REG_W | Write data, where bit n is the mask bit of line n |
| reg_rdata | output | REG_W | Read data of the selected register, zero-extended |
| irq_req | output | 1 | Registered interrupt request to the processor |

## Verification
The bench first raises and drops single lines with the mask clear and then set. This separates a controller that latches masked events from one that wipes them, and it checks both ends of the line index range. Next it changes several lines on one edge, with a mix of masked and enabled lines, and then drops the only enabled pending line while a masked line stays high. This shows whether the whole word is cleared or only the changed bit. The last sequences rewrite the mask with no line activity and hold lines steady across many edges. They tell an event-driven controller apart from one that re-evaluates every cycle or on mask writes. A write to the status address confirms that this register is read-only.

// File: rtl/lvlic_pkg.sv
package lvlic_pkg;

   // Register selector values seen on reg_addr.
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_MASK   = 1'b1
   } reg_sel_e;

endpackage

// File: rtl/lvlic_edge_det.sv
// Per-line change detector: compares each line with its value at the previous edge.
module lvlic_edge_det #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   output logic [NUM_LINES-1:0] rise_o,
   output logic [NUM_LINES-1:0] fall_o,
   output logic                 any_chg_o
);

   logic [NUM_LINES-1:0] prev_q;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[g] <= 1'b0;
         else        prev_q[g] <= lines_i[g];
      end
      assign rise_o[g] =  lines_i[g] & ~prev_q[g];
      assign fall_o[g] = ~lines_i[g] &  prev_q[g];
   end

   assign any_chg_o = |(lines_i ^ prev_q);

   // R3 support: a falling line was high one edge earlier
   a_r3_fall_had_high: assert property (@(posedge clk) disable iff (!rst_n)
      (|fall_o) |=> ((prev_q & $past(fall_o)) == '0));

endmodule

// File: rtl/lvlic_mask_reg.sv
// Software-written enable word.
module lvlic_mask_reg #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic [NUM_LINES-1:0] wdata_i,
   output logic [NUM_LINES-1:0] mask_q_o,
   output logic [NUM_LINES-1:0] mask_d_o
);

   assign mask_d_o = wr_i ? wdata_i : mask_q_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q_o <= '0;
      else        mask_q_o <= mask_d_o;
   end

   // R7: a write lands at the next edge
   a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_q_o == $past(wdata_i)));

   // R7: without a write the mask holds
   a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_q_o));

endmodule

// File: rtl/lvlic_status.sv
// Pending-status word with the clear-all rule and the registered request.
module lvlic_status #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] rise_i,
   input  logic [NUM_LINES-1:0] fall_i,
   input  logic                 any_chg_i,
   input  logic [NUM_LINES-1:0] mask_q_i,
   input  logic [NUM_LINES-1:0] mask_d_i,
   output logic [NUM_LINES-1:0] status_q_o,
   output logic                 req_q_o
);

   logic [NUM_LINES-1:0] upd;
   logic [NUM_LINES-1:0] status_d;

   always_comb begin
      upd = (status_q_o | rise_i) & ~fall_i;
      if (any_chg_i) status_d = (|(upd & mask_q_i)) ? upd : '0;
      else           status_d = status_q_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q_o <= '0;
         req_q_o    <= 1'b0;
      end else begin
         status_q_o <= status_d;
         req_q_o    <= |(status_d & mask_d_i);
      end
   end

   // R4: request tracks the registered status and mask
   a_r4_req_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      req_q_o == |(status_q_o & mask_q_i));

   // R8 / R10: no line activity, no status change
   a_r8_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      !any_chg_i |=> $stable(status_q_o));

   // R5: after an event with an unchanged mask, either a request or an empty word
   a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (any_chg_i && (mask_d_i == mask_q_i)) |=> (req_q_o || (status_q_o == '0)));

   // R2: risen bits are set unless the whole word was wiped
   a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise_i) |=> (((status_q_o & $past(rise_i)) == $past(rise_i)) || (status_q_o == '0)));

   // R3: fallen bits are clear
   a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (|fall_i) |=> ((status_q_o & $past(fall_i)) == '0));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
   parameter int NUM_LINES = 32,
   parameter int REG_W     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 reg_wr_en,
   input  logic                 reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic                 irq_req
);
   import lvlic_pkg::*;

   if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_width
      $error("lvl_irq_ctrl: NUM_LINES must be between 1 and REG_W");
   end

   logic [NUM_LINES-1:0] rise, fall, mask_q, mask_d, status_q;
   logic                 any_chg;
   logic                 mask_wr;

   assign mask_wr = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_MASK);

   lvlic_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines_i   (irq_lines),
      .rise_o    (rise),
      .fall_o    (fall),
      .any_chg_o (any_chg)
   );

   lvlic_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (mask_wr),
      .wdata_i  (reg_wdata[NUM_LINES-1:0]),
      .mask_q_o (mask_q),
      .mask_d_o (mask_d)
   );

   lvlic_status #(.NUM_LINES(NUM_LINES)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise),
      .fall_i     (fall),
      .any_chg_i  (any_chg),
      .mask_q_i   (mask_q),
      .mask_d_i   (mask_d),
      .status_q_o (status_q),
      .req_q_o    (irq_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_sel_e'(reg_addr) == SEL_MASK) reg_rdata[NUM_LINES-1:0] = mask_q;
      else                                  reg_rdata[NUM_LINES-1:0] = status_q;
   end

   // R9: writes aimed at the status address leave it alone
   a_r9_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && (reg_sel_e'(reg_addr) == SEL_STATUS) && !any_chg) |=> $stable(status_q));

   // R8: a mask write with no line event keeps status
   a_r8_mask_wr_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && !any_chg) |=> $stable(status_q));

endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb_top;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_lines = '0;
   logic          reg_wr_en = 1'b0;
   logic          reg_addr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_req;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;   // 125 MHz

   lvl_irq_ctrl #(.NUM_LINES(N), .REG_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_req(irq_req)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // advance one edge, then settle 2 ns after it
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic read_reg(input logic a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic expect_state(input string req, input logic [31:0] st,
                               input logic rq);
      logic [31:0] v;
      read_reg(1'b0, v);
      check(req, "status", v, st);
      check(req, "irq_req", {31'b0, irq_req}, {31'b0, rq});
   endtask

   task automatic write_mask(input logic [31:0] m);
      reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = m;
      tick();
      reg_wr_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      expect_state("R1", 32'h0, 1'b0);
      read_reg(1'b1, v);
      check("R1", "mask", v, 32'h0);
   endtask

   task automatic t_masked_rise();
      irq_lines = 32'h8; tick();
      expect_state("R6", 32'h0, 1'b0);
      irq_lines = 32'h0; tick();
      expect_state("R6", 32'h0, 1'b0);
   endtask

   task automatic t_mask_write();
      logic [31:0] v;
      reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h8000_0011;
      #1;
      check("R7", "mask before edge", reg_rdata, 32'h0);
      tick();
      reg_wr_en = 1'b0;
      read_reg(1'b1, v);
      check("R7", "mask after edge", v, 32'h8000_0011);
   endtask

   task automatic t_status_write();
      reg_wr_en = 1'b1; reg_addr = 1'b0; reg_wdata = 32'hFFFF_FFFF;
      tick();
      reg_wr_en = 1'b0;
      expect_state("R9", 32'h0, 1'b0);
   endtask

   task automatic t_rise();
      irq_lines = 32'h10; tick();
      expect_state("R2", 32'h10, 1'b1);
      irq_lines = 32'h8000_0010; tick();
      expect_state("R2 top line", 32'h8000_0010, 1'b1);
      irq_lines = 32'h10; tick();
      expect_state("R3 top line", 32'h10, 1'b1);
   endtask

   task automatic t_multi();
      irq_lines = 32'h211; tick();
      expect_state("R11", 32'h211, 1'b1);
   endtask

   task automatic t_fall();
      irq_lines = 32'h201; tick();
      expect_state("R3", 32'h201, 1'b1);
   endtask

   task automatic t_clear_all();
      irq_lines = 32'h200; tick();
      expect_state("R5", 32'h0, 1'b0);
   endtask

   task automatic t_steady();
      for (int i = 0; i < 3; i++) tick();
      expect_state("R10", 32'h0, 1'b0);
      write_mask(32'h211);
      expect_state("R8 steady", 32'h0, 1'b0);
      irq_lines = 32'h0; tick();
      expect_state("R10 drop", 32'h0, 1'b0);
      irq_lines = 32'h200; tick();
      expect_state("R10 rerise", 32'h200, 1'b1);
   endtask

   task automatic t_no_reeval();
      irq_lines = 32'h201; tick();
      expect_state("R2", 32'h201, 1'b1);
      write_mask(32'h10);
      expect_state("R8", 32'h201, 1'b0);
      irq_lines = 32'h211; tick();
      expect_state("R4", 32'h211, 1'b1);
      write_mask(32'h0);
      expect_state("R8 zero mask", 32'h211, 1'b0);
      irq_lines = 32'h011; tick();
      expect_state("R5 masked", 32'h0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL R0 watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      tick();
      t_reset();
      t_masked_rise();
      t_mask_write();
      t_status_write();
      t_rise();
      t_multi();
      t_fall();
      t_clear_all();
      t_steady();
      t_no_reeval();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule